// File: doc/BRIEF.md
# Logarithmic Master Volume Scaler

The block scales a stream of 16-bit signed audio samples by a gain chosen with an 8-bit volume code. The gain follows a logarithmic law. Each code step moves the gain by 0.1875 dB, code E0h is unity, and code FFh gives +5.8125 dB. The linear multiplier for every code is computed when the design is elaborated and kept as an unsigned fixed-point constant with 14 fraction bits. Each sample is multiplied by this constant, rounded to the nearest integer and clamped to the 16-bit signed range. Clamping is needed because codes above unity can push a full-scale sample past the limits.

Samples arrive on a valid/ready input stream and leave on a valid/ready output stream through a single register stage. A word is accepted in any cycle where `in_valid` and `in_ready` are both high. A result is taken in any cycle where `out_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the pending result stays unchanged and `in_ready` stays low. The producer must then keep its word on the input until the word is accepted. The volume code is written through a plain write strobe and can change at any time, including while samples stream. Each sample uses exactly one code: the code held in the register when that sample is accepted.

Top module: `mvol_scaler`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high and the volume code is E0h, so the first sample passes unchanged.
- R2: Code c selects coefficient round(16384 × 10^((c − 224) × 0.1875 / 20)). This is an unsigned value with 14 fraction bits, and ties round upward.
- R3: The output is (sample × coefficient + 8192) arithmetically shifted right by 14. This rounds to nearest, with ties toward positive infinity.
- R4: A result above 32767 is output as 32767, and a result below −32768 is output as −32768.
- R5: With code E0h every sample, including −32768 and 32767, is output bit-exact.
- R6: The extreme codes follow the same law: code 00h is −42 dB and code FFh is +5.8125 dB.
- R7: A write (`vol_we` high) in the same cycle as an accepted sample does not affect that sample. Every later sample uses the written code.
- R8: A sample accepted at a clock edge appears on `out_data` with `out_valid` high right after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low. Raising `out_ready` raises `in_ready` in the same cycle.
- R10: With `out_ready` held high, one sample per cycle is accepted and delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vol_we | input | 1 | Volume code write strobe |
| vol_wdata | input | 8 | Volume code to write |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | 16 | Scaled, rounded and saturated sample |

## Verification
The bench sweeps all 256 codes with full-scale positive and negative words and a pseudo-random word. A wrongly built table, or rounding that truncates instead of rounding to nearest, shows up as an off-by-one result somewhere in that sweep. Full-scale inputs at codes above unity expose missing clamping, which would wrap to the opposite sign, and sign-extension faults on −32768. A volume write made in the same cycle as an accepted sample catches a design that applies the new gain one sample too early. A stalled consumer shows whether a design overwrites a held result or drops or duplicates a word when the stall is released.

// File: rtl/mvol_pkg.sv
package mvol_pkg;

  // Linear gain for one code, in unsigned fixed point with frac_w fraction bits.
  // step_e4 is the dB change per code in units of 0.0001 dB.
  function automatic logic [31:0] gain_coef(input int code, input int unity,
                                            input int step_e4, input int frac_w);
    real db;
    real lin;
    db  = real'(code - unity) * real'(step_e4) / 10000.0;
    lin = 10.0 ** (db / 20.0);
    return 32'($rtoi(lin * (2.0 ** frac_w) + 0.5));
  endfunction

endpackage

// File: rtl/mvol_coef_rom.sv
module mvol_coef_rom #(
  parameter int CODE_W  = 8,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int UNITY   = 224,
  parameter int STEP_E4 = 1875
) (
  input  logic [CODE_W-1:0] code,
  output logic [COEF_W-1:0] coef
);
  localparam int DEPTH = 1 << CODE_W;

  logic [COEF_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [31:0] VAL = mvol_pkg::gain_coef(i, UNITY, STEP_E4, FRAC_W);
    assign tbl[i] = VAL[COEF_W-1:0];
  end

  assign coef = tbl[code];
endmodule

// File: rtl/mvol_mul_sat.sv
module mvol_mul_sat #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0] coef,
  output logic [DATA_W-1:0] result
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MIN_V = -(MAX_V + PROD_W'(1));

  logic signed [PROD_W-1:0] a_ext, b_ext, prod, rnd, scaled;

  assign a_ext  = {{(PROD_W - DATA_W){sample[DATA_W-1]}}, sample};
  assign b_ext  = {{(PROD_W - COEF_W){1'b0}}, coef};
  assign prod   = a_ext * b_ext;
  assign rnd    = prod + HALF;
  assign scaled = rnd >>> FRAC_W;

  always_comb begin
    if (scaled > MAX_V)      result = MAX_V[DATA_W-1:0];
    else if (scaled < MIN_V) result = MIN_V[DATA_W-1:0];
    else                     result = scaled[DATA_W-1:0];
  end
endmodule

// File: rtl/mvol_out_stage.sv
module mvol_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic vld_q;
  logic [DATA_W-1:0] dat_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      dat_q <= in_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/mvol_scaler.sv
module mvol_scaler #(
  parameter int DATA_W     = 16,
  parameter int CODE_W     = 8,
  parameter int FRAC_W     = 14,
  parameter int UNITY_CODE = 224,
  parameter int STEP_E4    = 1875
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vol_we,
  input  logic [CODE_W-1:0] vol_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int COEF_W = FRAC_W + 2;
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(UNITY_CODE);

  logic [CODE_W-1:0] code_q;
  logic [COEF_W-1:0] coef;
  logic [DATA_W-1:0] scaled;

  // The code changes only at a clock edge, so a sample accepted at an edge
  // always sees the value held before that edge.
  always_ff @(posedge clk) begin
    if (!rst_n)      code_q <= RST_CODE;
    else if (vol_we) code_q <= vol_wdata;
  end

  mvol_coef_rom #(
    .CODE_W(CODE_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .UNITY(UNITY_CODE), .STEP_E4(STEP_E4)
  ) u_rom (
    .code(code_q),
    .coef(coef)
  );

  mvol_mul_sat #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)
  ) u_mul (
    .sample(in_data),
    .coef(coef),
    .result(scaled)
  );

  mvol_out_stage #(
    .DATA_W(DATA_W)
  ) u_stage (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_data(scaled),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data(out_data)
  );
endmodule

// File: rtl/mvol_scaler_chk.sv
module mvol_scaler_chk #(
  parameter int DATA_W     = 16,
  parameter int CODE_W     = 8,
  parameter int UNITY_CODE = 224
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vol_we,
  input logic [CODE_W-1:0] vol_wdata,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CODE_W-1:0] code_q
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_unity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && code_q == CODE_W'(UNITY_CODE) |=> out_data == $past(in_data));

  assert_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vol_we |=> code_q == $past(vol_wdata));

  assert_flow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

bind mvol_scaler mvol_scaler_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .UNITY_CODE(UNITY_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vol_we(vol_we), .vol_wdata(vol_wdata),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .code_q(code_q)
);

// File: tb/mvol_scaler_tb.sv
module mvol_scaler_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vol_we = 1'b0;
  logic [7:0] vol_wdata = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int cur_code = 224;
  bit done = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  mvol_scaler u_dut (
    .clk(clk), .rst_n(rst_n), .vol_we(vol_we), .vol_wdata(vol_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic longint coef_of(input int code);
    real g;
    g = 10.0 ** ((real'(code) - 224.0) * 0.1875 / 20.0);
    return longint'($rtoi(g * 16384.0 + 0.5));
  endfunction

  function automatic logic [15:0] model(input logic [15:0] d, input int code);
    longint p;
    longint r;
    p = longint'($signed(d)) * coef_of(code);
    r = (p + 8192) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[31:16];
  endfunction

  task automatic set_code(input int c);
    @(negedge clk);
    vol_we = 1'b1;
    vol_wdata = 8'(c);
    @(negedge clk);
    vol_we = 1'b0;
    cur_code = c;
  endtask

  task automatic xfer(input logic [15:0] d, input string req);
    logic [15:0] e;
    e = model(d, cur_code);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " valid"}, longint'(out_valid), 1);
    chk(out_data === e, req, longint'($signed(out_data)), longint'($signed(e)));
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
    xfer(16'h1357, "R1 default code is unity");
  endtask

  task automatic t_unity();
    set_code(224);
    xfer(16'h8000, "R5 unity -32768");
    xfer(16'h7FFF, "R5 unity 32767");
    xfer(16'hFFFF, "R5 unity -1");
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 256; c++) begin
      set_code(c);
      xfer(16'h7FFF, "R2 R3 sweep +full");
      xfer(16'h8000, "R2 R4 sweep -full");
      xfer(next_rand(), "R2 R3 sweep random");
    end
  endtask

  task automatic t_extremes();
    set_code(255);
    xfer(16'd30000, "R4 R6 clamp high at FFh");
    xfer(16'h8AD0, "R4 R6 clamp low at FFh");
    xfer(16'd1000, "R6 gain at FFh");
    set_code(0);
    xfer(16'h7FFF, "R6 -42 dB at 00h");
    xfer(16'd63, "R3 small value at 00h");
  endtask

  task automatic t_write_mid();
    logic [15:0] e1;
    logic [15:0] e2;
    set_code(200);
    e1 = model(16'd20000, 200);
    e2 = model(16'd20000, 250);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_data = 16'd20000;
    vol_we = 1'b1;
    vol_wdata = 8'd250;
    @(negedge clk);
    vol_we = 1'b0;
    cur_code = 250;
    chk(out_data === e1, "R7 sample in write cycle uses old code",
        longint'($signed(out_data)), longint'($signed(e1)));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data === e2, "R7 next sample uses new code",
        longint'($signed(out_data)), longint'($signed(e2)));
  endtask

  task automatic t_backpressure();
    logic [15:0] e1;
    logic [15:0] e2;
    set_code(230);
    e1 = model(16'd12345, 230);
    e2 = model(16'hC000, 230);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = 16'd12345;
    @(negedge clk);
    in_data = 16'hC000;
    chk(out_valid === 1'b1, "R8 valid one cycle after accept", longint'(out_valid), 1);
    chk(in_ready === 1'b0, "R9 in_ready low when stalled", longint'(in_ready), 0);
    @(negedge clk);
    chk(out_data === e1, "R9 data held under stall",
        longint'($signed(out_data)), longint'($signed(e1)));
    chk(out_valid === 1'b1, "R9 valid held under stall", longint'(out_valid), 1);
    out_ready = 1'b1;
    #0;
    chk(in_ready === 1'b1, "R9 in_ready follows out_ready", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data === e2, "R9 second word after release",
        longint'($signed(out_data)), longint'($signed(e2)));
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 valid drops after drain", longint'(out_valid), 0);
  endtask

  task automatic t_stream();
    logic [15:0] prev_e;
    logic [15:0] d;
    set_code(180);
    out_ready = 1'b1;
    prev_e = '0;
    for (int i = 0; i < 24; i++) begin
      d = next_rand();
      @(negedge clk);
      if (i > 0) begin
        chk(out_valid === 1'b1 && out_data === prev_e, "R10 back-to-back order",
            longint'($signed(out_data)), longint'($signed(prev_e)));
        chk(in_ready === 1'b1, "R10 ready every cycle", longint'(in_ready), 1);
      end
      in_valid = 1'b1;
      in_data = d;
      prev_e = model(d, 180);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data === prev_e, "R10 last word",
        longint'($signed(out_data)), longint'($signed(prev_e)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unity();
    t_extremes();
    t_write_mid();
    t_backpressure();
    t_stream();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule